// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM with a 17-bit address and an 8-bit data path. The host offers one access at a time on a valid/ready request channel: an address, a byte of write data and a write flag. The controller turns each accepted request into a complete SRAM bus cycle. It drives the active-low chip-enable, write-enable and output-enable strobes, the address and the outgoing data with its drive enable. Read data comes back on a valid/ready response channel.

All SRAM timing limits are given as nanosecond parameters together with the clock period. Each limit becomes a cycle count, rounded up. A write window is the time in which chip enable and write enable are both low. A build-time parameter picks which strobe closes the window. The data hold and the recovery gap then follow the limits for that strobe. The data pins are split into an output, an output enable and an input, so the pad tristate stays outside the block.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. Request fields are sampled only on that edge. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. Until that edge, `rsp_valid` and `rsp_data` hold steady, and no new request is accepted while an unconsumed response is held.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the three strobes are high, `sram_dq_oe` is 0 and `rsp_valid` is 0. After release, with no response pending, `req_ready` is 1.
- R2: A read accepted on edge N drives `sram_addr` with the request address on edge N. Chip enable and output enable go low on edge N+1 with write enable high. The byte on `sram_dq_i` is captured on edge N+1+A, where A is the larger of the address and output-enable access times in cycles (4 at default). On that same edge `rsp_valid` rises with the byte on `rsp_data`, and both strobes return high.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` stay unchanged and `req_ready` stays 0.
- R4: A write accepted on edge N takes chip enable and write enable low on edge N+1. They stay low together for W cycles, where W is the larger of the write-pulse and data-setup limits in cycles, with a minimum of 1 (3 at default). From edge N+1, `sram_dq_oe` is 1 and `sram_dq_o` holds the request byte.
- R5: With END_BY_CE = 0, write enable rises first and closes the window. Chip enable, `sram_dq_oe` and the data stay put for H cycles more, where H is the write-enable hold limit in cycles with a minimum of 1 (1 at default).
- R6: With END_BY_CE = 1, chip enable rises first and closes the window. Write enable, `sram_dq_oe` and the data stay put for H cycles more, where H is the chip-enable hold limit in cycles with a minimum of 1 (1 at default).
- R7: Two accepted requests are at least the cycle-time count apart. The first edge at which a request can be accepted after a write comes at least R cycles after the window closes, where R is the recovery limit for the closing strobe. At default and with `rsp_ready` held at 1, back-to-back requests are accepted exactly 6 edges apart after a write and 6 edges apart after a read.
- R8: `sram_addr` changes only on an accept edge. It does not change while chip enable or write enable is low, and it is stable for at least one clock before either strobe falls.
- R9: `req_ready` is 1 only when all three strobes are high.
- R10: Output enable is never low while write enable is low, and `sram_dq_oe` is never 1 while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Host takes the read byte |
| rsp_data | output | 8 | Read byte |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 17 | SRAM address |
| sram_dq_o | output | 8 | Data toward the SRAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 8 | Data from the SRAM |

## Verification
The assertions place no constraint on the host: request fields are sampled only on the accept edge, and `rsp_ready` may toggle freely. The properties rely only on reset being low from time zero. The write-pulse property measures the window against the limit recomputed from the same nanosecond parameters. The stimulus holds each request steady until it is accepted. It drops `rsp_ready` only once, while a single read response is pending. It runs one controller for each closing strobe from identical requests, so both termination orders are seen on the same traffic.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD_ACC,
    ST_WR_PULSE,
    ST_WR_HOLD
  } bus_state_e;

  // round a nanosecond limit up to whole clock periods
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned min1(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
`timescale 1ns/1ps
module sram_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (load)
      count <= load_val;
    else if (count != '0)
      count <= count - W'(1);
  end

  assign zero = (count == '0);

endmodule

// File: rtl/sram_rsp_hold.sv
`timescale 1ns/1ps
module sram_rsp_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (capture) begin
      rsp_valid <= 1'b1;
      rsp_data  <= cap_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_RC_NS       = 70,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 55,
  parameter int T_DS_NS       = 30,
  parameter int T_DH_WE_NS    = 0,
  parameter int T_WR_WE_NS    = 5,
  parameter int T_DH_CE_NS    = 10,
  parameter int T_WR_CE_NS    = 15,
  parameter bit END_BY_CE     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned PER      = CLK_PERIOD_NS;
  localparam int unsigned ACC_CYC  = min1(ns_to_cyc(max2(T_ACC_NS, T_OE_NS), PER));
  localparam int unsigned WP_CYC   = min1(max2(ns_to_cyc(T_WP_NS, PER), ns_to_cyc(T_DS_NS, PER)));
  localparam int unsigned HOLD_CYC = min1(ns_to_cyc(END_BY_CE ? T_DH_CE_NS : T_DH_WE_NS, PER));
  localparam int unsigned REC_CYC  = ns_to_cyc(END_BY_CE ? T_WR_CE_NS : T_WR_WE_NS, PER);
  localparam int unsigned CYC_CYC  = min1(ns_to_cyc(max2(T_RC_NS, T_WC_NS), PER));
  localparam int unsigned MAX_CYC  = max2(max2(max2(ACC_CYC, WP_CYC), max2(HOLD_CYC, REC_CYC)), CYC_CYC);
  localparam int          CNT_W    = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'((REC_CYC == 0) ? 0 : REC_CYC - 1);
  localparam logic [CNT_W-1:0] CYC_LD  = CNT_W'(CYC_CYC - 1);

  bus_state_e state;
  logic       is_wr;
  logic       accept;
  logic       ph_load, ph_zero;
  logic [CNT_W-1:0] ph_val, ph_cnt;
  logic       gap_load, gap_zero;
  logic [CNT_W-1:0] gap_cnt;
  logic       cyc_zero;
  logic [CNT_W-1:0] cyc_cnt;
  logic       capture;
  logic       win_close;

  // ---------------- handshake ----------------
  assign req_ready = (state == ST_IDLE) && gap_zero && cyc_zero && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  // ---------------- counter control ----------------
  assign win_close = (state == ST_WR_PULSE) && ph_zero;
  assign capture   = (state == ST_RD_ACC) && ph_zero;
  assign ph_load   = (state == ST_SETUP) || win_close;
  assign ph_val    = (state == ST_SETUP) ? (is_wr ? WP_LD : ACC_LD) : HOLD_LD;
  assign gap_load  = win_close;

  // phase timer: access, pulse and hold lengths
  sram_wait_cnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
    .count(ph_cnt), .zero(ph_zero)
  );

  // recovery timer started when the write window closes
  sram_wait_cnt #(.W(CNT_W)) u_recover (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(GAP_LD),
    .count(gap_cnt), .zero(gap_zero)
  );

  // bus cycle-time timer started at every accept
  sram_wait_cnt #(.W(CNT_W)) u_cycle (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(CYC_LD),
    .count(cyc_cnt), .zero(cyc_zero)
  );

  sram_rsp_hold #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cap_data(sram_dq_i),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // ---------------- bus sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      is_wr      <= 1'b0;
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_dq_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            sram_addr <= req_addr;
            sram_dq_o <= req_wdata;
            is_wr     <= req_write;
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          sram_ce_n <= 1'b0;
          if (is_wr) begin
            sram_we_n  <= 1'b0;
            sram_dq_oe <= 1'b1;
            state      <= ST_WR_PULSE;
          end else begin
            sram_oe_n <= 1'b0;
            state     <= ST_RD_ACC;
          end
        end
        ST_RD_ACC: begin
          if (ph_zero) begin
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_WR_PULSE: begin
          if (ph_zero) begin
            if (END_BY_CE) sram_ce_n <= 1'b1;
            else           sram_we_n <= 1'b1;
            state <= ST_WR_HOLD;
          end
        end
        ST_WR_HOLD: begin
          if (ph_zero) begin
            sram_ce_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
`timescale 1ns/1ps
module sram_bus_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_WP_NS       = 55,
  parameter int T_DS_NS       = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe
);

  localparam int unsigned WP_MIN =
    min1(max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS), ns_to_cyc(T_DS_NS, CLK_PERIOD_NS)));

  logic        win;
  logic [15:0] win_len;

  assign win = !sram_ce_n && !sram_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   win_len <= '0;
    else if (win) win_len <= win_len + 16'd1;
    else          win_len <= '0;
  end

  // R4: the overlap of both strobes lasts at least the pulse limit
  assert_wp_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win) && !win) |-> (win_len >= 16'(WP_MIN)));

  // R4: driven write data does not move while driven
  assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

  // R5 / R6: exactly one strobe closes the window, the other stays low
  assert_one_strobe_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win) && !win) |-> (sram_ce_n != sram_we_n));

  // R6: data still driven in the cycle after the window closes
  assert_hold_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win) && !win) |-> sram_dq_oe);

  // R3: held response is stable under back-pressure
  assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8: address frozen while chip enable is low, and set up before it falls
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));
  assert_addr_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_ce_n) |-> $stable(sram_addr));

  // R9: ready only with the bus parked
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n));

  // R10: no output enable during a write, no drive during a read
  assert_no_oe_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);
  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .sram_ce_n(sram_ce_n),
  .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
  .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_model.sv
`timescale 1ns/1ps
module sram_model #(
  parameter int AW  = 17,
  parameter int DW  = 8,
  parameter int ACC = 4
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_o,
  input  logic          dq_oe,
  output logic [DW-1:0] dq_i,
  output int            win_min,
  output int            n_we_first,
  output int            n_ce_first,
  output int            n_both,
  output int            hold_min,
  output int            hold_max,
  output int            n_drive_bad,
  output int            n_addr_bad,
  output int            n_oe_bad
);

  logic [DW-1:0] mem [int];
  bit            prev_win, prev_low, in_hold;
  int            win_len, hold_len, rd_cnt;
  logic [AW-1:0] prev_addr;

  initial begin
    dq_i = '0; win_min = 1000; hold_min = 1000; hold_max = 0;
    n_we_first = 0; n_ce_first = 0; n_both = 0;
    n_drive_bad = 0; n_addr_bad = 0; n_oe_bad = 0;
    prev_win = 0; prev_low = 0; in_hold = 0;
    win_len = 0; hold_len = 0; rd_cnt = 0; prev_addr = '0;
  end

  always @(negedge clk) begin
    bit win, low;
    win = !ce_n && !we_n;
    low = !ce_n || !we_n;
    if (win) begin
      if (!dq_oe) n_drive_bad++;
      mem[int'(addr)] = dq_o;
      win_len++;
    end
    if (prev_win && !win) begin
      if (win_len < win_min) win_min = win_len;
      if (ce_n && we_n)  n_both++;
      else if (we_n)     n_we_first++;
      else               n_ce_first++;
      win_len  = 0;
      in_hold  = 1;
      hold_len = 0;
    end
    if (in_hold) begin
      if (low) begin
        hold_len++;
        if (!dq_oe) n_drive_bad++;
      end else begin
        if (hold_len < hold_min) hold_min = hold_len;
        if (hold_len > hold_max) hold_max = hold_len;
        in_hold = 0;
      end
    end
    if ((low || prev_low) && addr != prev_addr) n_addr_bad++;
    if (!oe_n && !we_n) n_oe_bad++;
    if (dq_oe && !oe_n) n_oe_bad++;
    if (!ce_n && !oe_n && we_n) rd_cnt++;
    else rd_cnt = 0;
    if (rd_cnt >= ACC) dq_i <= mem.exists(int'(addr)) ? mem[int'(addr)] : '0;
    else               dq_i <= 8'hA5;
    prev_win  = win;
    prev_low  = low;
    prev_addr = addr;
  end

endmodule

// File: tb/sram_bus_ctrl_bench.sv
`timescale 1ns/1ps
module sram_bus_ctrl_bench;

  localparam int AW     = 17;
  localparam int DW     = 8;
  localparam int PER    = 20;
  localparam int ACC_C  = (70 + PER - 1) / PER;
  localparam int WP_C   = (55 + PER - 1) / PER;
  localparam int HOLD_C = 1;
  localparam int REC_C  = (15 + PER - 1) / PER;
  localparam int CYC_C  = (70 + PER - 1) / PER;
  localparam int W_GAP0 = (2 + WP_C + HOLD_C > 1 + WP_C + REC_C) ? 2 + WP_C + HOLD_C : 1 + WP_C + REC_C;
  localparam int W_GAP  = (W_GAP0 > CYC_C) ? W_GAP0 : CYC_C;
  localparam int R_GAP  = (ACC_C + 2 > CYC_C) ? ACC_C + 2 : CYC_C;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic req_ready, rsp_valid, ce_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rsp_data, dq_o, dq_i;
  logic [AW-1:0] sa;
  logic ready_b, rsp_valid_b, ce_n_b, we_n_b, oe_n_b, dq_oe_b;
  logic [DW-1:0] rsp_data_b, dq_o_b, dq_i_b;
  logic [AW-1:0] sa_b;

  always #(PER/2) clk = ~clk;

  sram_bus_ctrl u_sram_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sram_ce_n(ce_n), .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_addr(sa),
    .sram_dq_o(dq_o), .sram_dq_oe(dq_oe), .sram_dq_i(dq_i)
  );

  sram_bus_ctrl #(.END_BY_CE(1'b1)) u_sram_bus_ctrl_ce (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_b),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_b), .rsp_ready(rsp_ready), .rsp_data(rsp_data_b),
    .sram_ce_n(ce_n_b), .sram_we_n(we_n_b), .sram_oe_n(oe_n_b), .sram_addr(sa_b),
    .sram_dq_o(dq_o_b), .sram_dq_oe(dq_oe_b), .sram_dq_i(dq_i_b)
  );

  int a_win, a_we, a_ce, a_both, a_hmin, a_hmax, a_drv, a_addr, a_oe;
  int b_win, b_we, b_ce, b_both, b_hmin, b_hmax, b_drv, b_addr, b_oe;

  sram_model #(.AW(AW), .DW(DW), .ACC(ACC_C)) u_mem_a (
    .clk(clk), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(sa), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i), .win_min(a_win), .n_we_first(a_we),
    .n_ce_first(a_ce), .n_both(a_both), .hold_min(a_hmin), .hold_max(a_hmax),
    .n_drive_bad(a_drv), .n_addr_bad(a_addr), .n_oe_bad(a_oe)
  );

  sram_model #(.AW(AW), .DW(DW), .ACC(ACC_C)) u_mem_b (
    .clk(clk), .ce_n(ce_n_b), .we_n(we_n_b), .oe_n(oe_n_b), .addr(sa_b), .dq_o(dq_o_b),
    .dq_oe(dq_oe_b), .dq_i(dq_i_b), .win_min(b_win), .n_we_first(b_we),
    .n_ce_first(b_ce), .n_both(b_both), .hold_min(b_hmin), .hold_max(b_hmax),
    .n_drive_bad(b_drv), .n_addr_bad(b_addr), .n_oe_bad(b_oe)
  );

  typedef struct { logic [DW-1:0] data; int acc; } exp_t;
  exp_t sb[$];
  logic [DW-1:0] shadow [int];

  int n_tests = 0, n_fail = 0;
  int cyc = 0, last_acc = 0, nwr = 0;
  int ready_mis = 0, busy_ready = 0;
  bit seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int exp_gap);
    bit ok;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); ok = req_ready;
      @(posedge clk);
    end while (!ok);
    #1;
    req_valid = 0;
    if (exp_gap > 0) check(cyc - last_acc == exp_gap, "R7", cyc - last_acc, exp_gap, "accept spacing");
    last_acc = cyc;
    if (wr) begin
      shadow[int'(a)] = d;
      nwr++;
    end else begin
      exp_t e;
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
      e.acc  = cyc;
      sb.push_back(e);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (req_ready !== ready_b) ready_mis++;
    if (req_ready && (!ce_n || !we_n || !oe_n)) busy_ready++;
    if (rsp_valid && !seen) begin
      seen = 1;
      if (sb.size() == 0) check(0, "R2", 1, 0, "response with no read pending");
      else check(cyc - sb[0].acc == 1 + ACC_C, "R2", cyc - sb[0].acc, 1 + ACC_C, "read latency");
    end
    if (rsp_valid && rsp_ready && sb.size() > 0) begin
      check(rsp_data == sb[0].data, "R2", int'(rsp_data), int'(sb[0].data), "read data (WE-closing)");
      check(rsp_data_b == sb[0].data, "R6", int'(rsp_data_b), int'(sb[0].data), "read data (CE-closing)");
      void'(sb.pop_front());
      seen = 0;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 20000 expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(ce_n && we_n && oe_n, "R1", {ce_n, we_n, oe_n}, 7, "strobes in reset");
    check(!dq_oe && !rsp_valid, "R1", {dq_oe, rsp_valid}, 0, "drive/response in reset");
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", req_ready, 1, "ready after reset");
    check(ce_n && we_n && oe_n && !dq_oe, "R1", {ce_n, we_n, oe_n, dq_oe}, 14, "bus parked after reset");
    @(posedge clk); #1;

    // R4 R5 R6: back-to-back writes with corner addresses and patterns
    issue(1, 17'h00000, 8'h00, 0);
    issue(1, 17'h1FFFF, 8'hFF, W_GAP);
    issue(1, 17'h155AA, 8'h5A, W_GAP);
    issue(1, 17'h0AA55, 8'hA5, W_GAP);
    // R2: back-to-back reads, first after a write
    issue(0, 17'h00000, 8'h00, W_GAP);
    issue(0, 17'h1FFFF, 8'h00, R_GAP);
    issue(0, 17'h155AA, 8'h00, R_GAP);
    issue(0, 17'h0AA55, 8'h00, R_GAP);
    issue(0, 17'h01234, 8'h00, R_GAP);   // never written
    // overwrite then read, read then write
    issue(1, 17'h00000, 8'h3C, R_GAP);
    issue(0, 17'h00000, 8'h00, W_GAP);
    issue(1, 17'h00001, 8'hC3, R_GAP);
    issue(0, 17'h00001, 8'h00, W_GAP);

    // R3: back-pressure on the response
    repeat (8) @(posedge clk);
    #1 rsp_ready = 0;
    issue(0, 17'h1FFFF, 8'h00, 0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == held, "R3", int'(rsp_data), int'(held), "response held");
      check(req_ready == 1'b0, "R3", req_ready, 0, "no accept while response held");
    end
    @(posedge clk); #1 rsp_ready = 1;
    issue(0, 17'h155AA, 8'h00, 0);

    while (sb.size() != 0) @(posedge clk);
    repeat (10) @(posedge clk);
    @(negedge clk);

    check(a_win == WP_C, "R4", a_win, WP_C, "shortest window (WE-closing)");
    check(b_win == WP_C, "R4", b_win, WP_C, "shortest window (CE-closing)");
    check(a_drv == 0 && b_drv == 0, "R4", a_drv + b_drv, 0, "data driven through window and hold");
    check(a_we == nwr && a_ce == 0 && a_both == 0, "R5", a_we, nwr, "write enable closes window");
    check(a_hmin == HOLD_C && a_hmax == HOLD_C, "R5", a_hmax, HOLD_C, "hold after write enable rises");
    check(b_ce == nwr && b_we == 0 && b_both == 0, "R6", b_ce, nwr, "chip enable closes window");
    check(b_hmin == HOLD_C && b_hmax == HOLD_C, "R6", b_hmax, HOLD_C, "hold after chip enable rises");
    check(a_addr == 0 && b_addr == 0, "R8", a_addr + b_addr, 0, "address stable around strobes");
    check(busy_ready == 0, "R9", busy_ready, 0, "ready only with bus parked");
    check(ready_mis == 0, "R9", ready_mis, 0, "both variants ready together");
    check(a_oe == 0 && b_oe == 0, "R10", a_oe + b_oe, 0, "no output enable or contention in writes");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule